// File: doc/BRIEF.md
# Multi-Range Charge-to-Time Hit Decoder

This block turns the hit list of one charge-to-time channel into a single measurement. The front end feeds three copies of one detector signal through high, middle and low gain stages. Each stage turns its charge into a discharge pulse. The three pulses are folded onto one timing line by exclusive-OR combination. When no stage overflows, the folded line carries four edges. When the high and middle stages overflow, only the two edges of the low-gain pulse survive. The block counts the edges of the channel and infers from that count which gain range holds valid data. It then reports the arrival time and the amplitude. The arrival time is the first (start) edge. The amplitude is the width of the chosen discharge interval, scaled onto one 16-bit linear axis.

Timestamps arrive as a valid/ready stream in rising time order. A beat flagged as end-of-channel carries no timestamp and closes the channel. One result record per channel leaves on a second valid/ready interface, together with a 2-bit range code and an error flag.

A two-state machine controls the flow:
- COLLECT: the block accepts beats. Each timestamp beat is stored and counted. The transition *close* (an end-of-channel beat is accepted) moves to EMIT and loads the result register.
- EMIT: the result is held with `out_valid` high and the input is back-pressured. The transition *drain* (the result is accepted) clears the edge store and returns to COLLECT.

Top module: `qt_range_decoder`

## Requirements
- R1: After reset the block is in COLLECT with `out_valid` low and `in_ready` high.
- R2: Four edges t0<t1<t2<t3 with an inner gap t2−t1 below `MID_LIMIT` (default 256) give range code 0 (high gain), amplitude t2−t1 unshifted, and time t0.
- R3: Four edges with an inner gap of `MID_LIMIT` or more give range code 1 (middle gain). The amplitude is (t3−t0) shifted left by `SH_MID` (default 4) bits, and the time is t0.
- R4: Exactly two edges give range code 2 (low gain). The amplitude is (t1−t0) shifted left by `SH_LOW` (default 8) bits, and the time is t0.
- R5: Any other edge count (0, 1, 3, or more than 4) gives range code 3 with `out_err` high, amplitude 0 and time 0. Edges beyond the fourth are counted but not stored.
- R6: A scaled amplitude that does not fit in `AW` bits saturates to all ones (0xFFFF by default).
- R7: `out_valid` rises in the cycle right after the edge that accepts the end-of-channel beat, and at no other time.
- R8: While a result waits for `out_ready`, the result stays stable, `in_ready` stays low, and a timestamp offered in that time is held by the source and taken only after the result leaves.
- R9: After a result is accepted, the next channel starts from an empty edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept a beat (COLLECT) |
| in_eoc | input | 1 | Beat is an end-of-channel marker, no timestamp |
| in_time | input | TW (16) | Edge timestamp |
| out_valid | output | 1 | Result record available |
| out_ready | input | 1 | Consumer takes the result |
| out_time | output | TW (16) | Arrival time (start edge), 0 on error |
| out_amp | output | AW (16) | Scaled amplitude, 0 on error |
| out_range | output | 2 | 0 high, 1 middle, 2 low, 3 error |
| out_err | output | 1 | Edge count did not match a valid range |

## Verification
The one overlap that matters is a result stalled by a consumer that is not ready while the source already offers the first timestamp of the next channel. The bench holds `out_ready` low for several cycles and presents a timestamp the whole time. It checks that the result fields do not move and that `in_ready` stays low. It then releases the result and checks that the held timestamp is taken into a fresh channel, whose low-gain decode must use that timestamp as its start. The table-driven pass also confirms that each result becomes visible exactly one cycle after its closing marker.

// File: rtl/qtd_pkg.sv
package qtd_pkg;

    // Range code carried on out_range; the numeric values are part of the interface.
    typedef enum logic [1:0] {
        RNG_HIGH = 2'd0,
        RNG_MID  = 2'd1,
        RNG_LOW  = 2'd2,
        RNG_ERR  = 2'd3
    } rng_e;

    // Edge counts that carry a valid measurement on the merged line.
    localparam int EDGES_FULL = 4;
    localparam int EDGES_LOW  = 2;

    // Controller states.
    typedef enum logic {
        S_COLLECT = 1'b0,
        S_EMIT    = 1'b1
    } fsm_e;

endpackage

// File: rtl/qtd_edge_store.sv
module qtd_edge_store #(
    parameter int TW    = 16,
    parameter int SLOTS = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          clear,
    input  logic [TW-1:0] t_in,
    output logic [TW-1:0] edges_o [SLOTS],
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] count_q;

    // Edge counter: saturates so that long hit lists still read as "too many".
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (push && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // One capture register per slot; slot g takes the g-th edge of the channel.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [TW-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (push && (count_q == CW'(g))) begin
                slot_q <= t_in;
            end
        end

        assign edges_o[g] = slot_q;
    end

    // R9: a drained channel leaves the counter empty.
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0));

    // R5: counting past the top value keeps the count pinned there.
    a_r5_count_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && (count_q == CNT_MAX)) |=> (count_q == CNT_MAX));

endmodule

// File: rtl/qtd_range_select.sv
module qtd_range_select
    import qtd_pkg::*;
#(
    parameter int TW        = 16,
    parameter int AW        = 16,
    parameter int CW        = 3,
    parameter int SLOTS     = 4,
    parameter int MID_LIMIT = 256,
    parameter int SH_MID    = 4,
    parameter int SH_LOW    = 8
) (
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] edges [SLOTS],
    output rng_e          rng_o,
    output logic [AW-1:0] amp_o,
    output logic [TW-1:0] time_o
);

    // Wide enough to see any bit pushed past the output width.
    localparam int WIDE = (TW + SH_LOW > AW) ? (TW + SH_LOW) : (AW + 1);
    localparam logic [TW-1:0] MID_LIMIT_V = TW'(MID_LIMIT);

    logic [TW-1:0]   gap_inner;
    logic [TW-1:0]   gap_outer;
    logic [TW-1:0]   gap_low;
    logic [TW-1:0]   gap_sel;
    logic [WIDE-1:0] scaled;
    int unsigned     shift;

    assign gap_inner = edges[2] - edges[1];
    assign gap_outer = edges[3] - edges[0];
    assign gap_low   = edges[1] - edges[0];

    // Pick the range from the edge count and the inner gap.
    always_comb begin
        rng_o   = RNG_ERR;
        gap_sel = '0;
        shift   = 0;
        time_o  = '0;
        if (count == CW'(EDGES_FULL)) begin
            time_o = edges[0];
            if (gap_inner < MID_LIMIT_V) begin
                rng_o   = RNG_HIGH;
                gap_sel = gap_inner;
                shift   = 0;
            end else begin
                rng_o   = RNG_MID;
                gap_sel = gap_outer;
                shift   = SH_MID;
            end
        end else if (count == CW'(EDGES_LOW)) begin
            time_o  = edges[0];
            rng_o   = RNG_LOW;
            gap_sel = gap_low;
            shift   = SH_LOW;
        end
    end

    // Scale onto the common axis and clamp at full scale.
    always_comb begin
        scaled = WIDE'(gap_sel) << shift;
        if (|scaled[WIDE-1:AW]) begin
            amp_o = '1;
        end else begin
            amp_o = scaled[AW-1:0];
        end
    end

endmodule

// File: rtl/qt_range_decoder.sv
module qt_range_decoder
    import qtd_pkg::*;
#(
    parameter int TW        = 16,
    parameter int AW        = 16,
    parameter int MID_LIMIT = 256,
    parameter int SH_MID    = 4,
    parameter int SH_LOW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_eoc,
    input  logic [TW-1:0] in_time,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [TW-1:0] out_time,
    output logic [AW-1:0] out_amp,
    output logic [1:0]    out_range,
    output logic          out_err
);

    localparam int SLOTS = EDGES_FULL;
    localparam int CW    = 3;
    localparam logic [AW-1:0] MID_MASK = AW'((1 << SH_MID) - 1);
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << SH_LOW) - 1);
    localparam logic [AW-1:0] HI_LIM   = AW'(MID_LIMIT);

    fsm_e state_q;
    fsm_e state_d;

    logic          beat_take;
    logic          push;
    logic          close;
    logic          drain;
    logic [TW-1:0] edges [SLOTS];
    logic [CW-1:0] count;
    rng_e          rng_c;
    logic [AW-1:0] amp_c;
    logic [TW-1:0] time_c;
    rng_e          rng_q;
    logic [AW-1:0] amp_q;
    logic [TW-1:0] time_q;

    assign beat_take = in_valid && in_ready;
    assign push      = beat_take && !in_eoc;
    assign close     = beat_take && in_eoc;
    assign drain     = out_valid && out_ready;

    qtd_edge_store #(
        .TW    (TW),
        .SLOTS (SLOTS),
        .CW    (CW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .clear   (drain),
        .t_in    (in_time),
        .edges_o (edges),
        .count_o (count)
    );

    qtd_range_select #(
        .TW        (TW),
        .AW        (AW),
        .CW        (CW),
        .SLOTS     (SLOTS),
        .MID_LIMIT (MID_LIMIT),
        .SH_MID    (SH_MID),
        .SH_LOW    (SH_LOW)
    ) u_select (
        .count  (count),
        .edges  (edges),
        .rng_o  (rng_c),
        .amp_o  (amp_c),
        .time_o (time_c)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: close (COLLECT -> EMIT), drain (EMIT -> COLLECT).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: if (close) state_d = S_EMIT;
            S_EMIT:    if (out_ready) state_d = S_COLLECT;
            default:   state_d = S_COLLECT;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            S_COLLECT: in_ready  = 1'b1;
            S_EMIT:    out_valid = 1'b1;
            default:   in_ready  = 1'b0;
        endcase
    end

    // Result record, captured on close.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q  <= RNG_ERR;
            amp_q  <= '0;
            time_q <= '0;
        end else if (close) begin
            rng_q  <= rng_c;
            amp_q  <= amp_c;
            time_q <= time_c;
        end
    end

    assign out_time  = time_q;
    assign out_amp   = amp_q;
    assign out_range = rng_q;
    assign out_err   = (rng_q == RNG_ERR);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && in_ready));

    a_r7_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eoc) |=> out_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_eoc));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_amp)
                                       && $stable(out_time) && $stable(out_range)));

    a_r8_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r5_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_range == 2'd3) |-> (out_amp == '0 && out_time == '0));

    a_r2_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_range == 2'd0) |-> (out_amp < HI_LIM));

    a_r3_mid_granule: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_range == 2'd1)
            |-> ((out_amp & MID_MASK) == '0 || out_amp == '1));

    a_r4_low_granule: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_range == 2'd2)
            |-> ((out_amp & LOW_MASK) == '0 || out_amp == '1));

endmodule

// File: tb/qt_range_decoder_tb_top.sv
module qt_range_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_eoc = 1'b0;
    logic [15:0] in_time = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_time;
    logic [15:0] out_amp;
    logic [1:0]  out_range;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    qt_range_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_eoc    (in_eoc),
        .in_time   (in_time),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_time  (out_time),
        .out_amp   (out_amp),
        .out_range (out_range),
        .out_err   (out_err)
    );

    typedef struct packed {
        logic [2:0]  n;
        logic [15:0] e0, e1, e2, e3, e4, e5;
        logic [15:0] xt;
        logic [15:0] xa;
        logic [1:0]  xr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd4, 16'd100,  16'd200,  16'd260,  16'd400,  16'd0,  16'd0,  16'd100,  16'd60,    2'd0}, // R2
        '{3'd4, 16'd1000, 16'd1010, 16'd1265, 16'd1300, 16'd0,  16'd0,  16'd1000, 16'd255,   2'd0}, // R2 edge
        '{3'd4, 16'd50,   16'd60,   16'd316,  16'd900,  16'd0,  16'd0,  16'd50,   16'd13600, 2'd1}, // R3
        '{3'd4, 16'd0,    16'd10,   16'd500,  16'd5000, 16'd0,  16'd0,  16'd0,    16'd65535, 2'd1}, // R6
        '{3'd2, 16'd300,  16'd400,  16'd0,    16'd0,    16'd0,  16'd0,  16'd300,  16'd25600, 2'd2}, // R4
        '{3'd2, 16'd10,   16'd266,  16'd0,    16'd0,    16'd0,  16'd0,  16'd10,   16'd65535, 2'd2}, // R6
        '{3'd2, 16'd7,    16'd262,  16'd0,    16'd0,    16'd0,  16'd0,  16'd7,    16'd65280, 2'd2}, // R4 edge
        '{3'd0, 16'd0,    16'd0,    16'd0,    16'd0,    16'd0,  16'd0,  16'd0,    16'd0,     2'd3}, // R5
        '{3'd1, 16'd500,  16'd0,    16'd0,    16'd0,    16'd0,  16'd0,  16'd0,    16'd0,     2'd3}, // R5
        '{3'd3, 16'd1,    16'd2,    16'd3,    16'd0,    16'd0,  16'd0,  16'd0,    16'd0,     2'd3}, // R5
        '{3'd5, 16'd1,    16'd2,    16'd3,    16'd4,    16'd5,  16'd0,  16'd0,    16'd0,     2'd3}, // R5
        '{3'd6, 16'd10,   16'd20,   16'd30,   16'd40,   16'd50, 16'd60, 16'd0,    16'd0,     2'd3}, // R5
        '{3'd2, 16'd20,   16'd30,   16'd0,    16'd0,    16'd0,  16'd0,  16'd20,   16'd2560,  2'd2}  // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic beat(input logic eoc, input logic [15:0] t);
        in_valid = 1'b1;
        in_eoc   = eoc;
        in_time  = t;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_eoc   = 1'b0;
    endtask

    task automatic take_result();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] ev [6];
            ev = '{VECS[v].e0, VECS[v].e1, VECS[v].e2, VECS[v].e3, VECS[v].e4, VECS[v].e5};
            for (int k = 0; k < int'(VECS[v].n); k++) beat(1'b0, ev[k]);
            check("R7 no result before marker", 32'(out_valid), 32'd0);
            beat(1'b1, 16'd0);
            check("R7 result one cycle after marker", 32'(out_valid), 32'd1);
            check("R2/R3/R4/R5 range", 32'(out_range), 32'(VECS[v].xr));
            check("R2/R3/R4/R5/R6 amplitude", 32'(out_amp), 32'(VECS[v].xa));
            check("R2/R3/R4/R5 time", 32'(out_time), 32'(VECS[v].xt));
            check("R5 error flag", 32'(out_err), 32'(VECS[v].xr == 2'd3));
            take_result();
            check("R9 back to collecting", 32'(in_ready), 32'd1);
        end

        // R8: result stalled while the next channel's first edge waits.
        beat(1'b0, 16'd100);
        beat(1'b0, 16'd200);
        beat(1'b0, 16'd260);
        beat(1'b0, 16'd400);
        beat(1'b1, 16'd0);
        in_valid = 1'b1;
        in_eoc   = 1'b0;
        in_time  = 16'd700;
        repeat (4) begin
            @(negedge clk);
            check("R8 result held", 32'(out_valid), 32'd1);
            check("R8 amplitude stable", 32'(out_amp), 32'd60);
            check("R8 input stalled", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R8 result released", 32'(out_valid), 32'd0);
        check("R8 input reopened", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        beat(1'b0, 16'd800);
        beat(1'b1, 16'd0);
        check("R8 held edge used as start", 32'(out_time), 32'd700);
        check("R8/R4 low range after stall", 32'(out_range), 32'd2);
        check("R8/R4 amplitude after stall", 32'(out_amp), 32'd25600);
        take_result();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule